// File: doc/BRIEF.md
# Single-Port Legacy I/O Controller

This block is the one I/O port of a small 8-bit home computer whose CPU has a separate I/O address space. Only address bit 0 is decoded. Any I/O access with an even address reaches the port, and any access with an odd address is ignored.

A port write does two things:
- It latches one data bit onto the tape-output line.
- It sets the speaker flip-flop, whatever the data value is.

A port read does three things:
- It clears the speaker flip-flop.
- It drives the keyboard row lines from the upper address byte.
- It returns a word that carries the keyboard column lines and the tape-input level.

The CPU produces a speaker tone just by alternating port writes and port reads.

The read path has a valid flag, `rd_valid`, and no ready signal. A CPU I/O cycle cannot be stalled, so this interface has no back-pressure. The read word must be used in the same cycle in which `rd_valid` is high. The control strobes are sampled on every rising clock edge. A strobe held for several cycles repeats its effect, and repeating it changes nothing.

Top module: `legacy_io_port`

## Requirements
- R1: The port is selected when address bit 0 is 0. A read or write strobe with address bit 0 equal to 1 changes no output.
- R2: On a selected write, data bit 3 is latched onto `tape_out` at the next clock edge. All other data bits have no effect.
- R3: A selected write sets `spkr` to 1 at the next clock edge, for any data value.
- R4: A selected read, with no write in the same cycle, clears `spkr` to 0 at the next clock edge.
- R5: During a selected read, the read word is laid out as follows:
  - bits 4:0 equal `key_cols_n`, where a pressed key reads 0;
  - bit 5 equals `tape_in`;
  - bits 7:6 are 1.
- R6: During a selected read, `key_rows_n` equals address bits 15:8, where a low bit selects its row. At all other times `key_rows_n` is 8'hFF.
- R7: `rd_valid` is 1 only when the port is selected and `io_rd` is 1. While `rd_valid` is 0, `rd_data` is 8'hFF.
- R8: When both strobes are active on a selected address in the same cycle, the write wins for the speaker (it ends at 1) and `tape_out` latches data bit 3. The read word is still returned.
- R9: A synchronous reset (`rst` high at a clock edge) clears `spkr` and `tape_out` to 0.
- R10: In a cycle with no selected strobe, `spkr` and `tape_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | CPU address bus |
| bus_wdata | input | 8 | CPU write data |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| key_cols_n | input | 5 | Keyboard column lines, active low |
| tape_in | input | 1 | Tape input level |
| rd_data | output | 8 | Read word, 8'hFF when not valid |
| rd_valid | output | 1 | Read word valid |
| key_rows_n | output | 8 | Keyboard row drives, active low |
| tape_out | output | 1 | Tape output line |
| spkr | output | 1 | Speaker line |

## Verification
The speaker set caused by a write and the speaker clear caused by a read can fall in the same clock cycle. The bench provokes this by raising `io_rd` and `io_wr` together on an even address, first with the speaker already cleared and then with it set. It judges the cycle on three things at once:
- the speaker must end at 1;
- `tape_out` must take data bit 3;
- the read word and row drives must still appear.

The bench also repeats the simultaneous case on an odd address, where nothing may change.

// File: rtl/legacy_io_pkg.sv
package legacy_io_pkg;
  localparam int ADDR_W_DEF  = 16;
  localparam int DATA_W_DEF  = 8;
  localparam int COL_W_DEF   = 5;
  localparam int MIC_BIT_DEF = 3;
  localparam int EAR_BIT_DEF = 5;

  // Kind of access seen on the bus in one cycle
  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
  import legacy_io_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int ROW_W  = ADDR_W / 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit,
  output acc_kind_e         kind,
  output logic [ROW_W-1:0]  rows_n
);
  localparam int ROW_LSB = ADDR_W - ROW_W;

  logic sel;

  // Only the lowest address bit takes part in the decode
  assign sel    = ~addr[0];
  assign rd_hit = sel & rd;
  assign wr_hit = sel & wr;
  assign kind   = acc_kind_e'({wr_hit, rd_hit});

  // Rows are driven only during a selected read; idle level is all ones
  always_comb begin
    rows_n = '1;
    if (rd_hit) rows_n = addr[ADDR_W-1:ROW_LSB];
  end
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import legacy_io_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int COL_W   = COL_W_DEF,
  parameter int EAR_BIT = EAR_BIT_DEF
) (
  input  logic              rd_hit,
  input  logic [COL_W-1:0]  cols_n,
  input  logic              ear,
  output logic [DATA_W-1:0] data,
  output logic              valid
);
  logic [DATA_W-1:0] word;

  // Unused bits read as 1; columns and tape level go to their fixed positions
  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      if (b < COL_W)         word[b] = cols_n[b];
      else if (b == EAR_BIT) word[b] = ear;
      else                   word[b] = 1'b1;
    end
  end

  assign valid = rd_hit;
  assign data  = rd_hit ? word : '1;
endmodule

// File: rtl/io_out_regs.sv
module io_out_regs
  import legacy_io_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int MIC_BIT = MIC_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic              mic_q,
  output logic              spk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mic_q <= 1'b0;
      spk_q <= 1'b0;
    end else begin
      unique case (kind)
        ACC_WRITE, ACC_BOTH: begin
          // A write sets the speaker, and wins over a read in the same cycle
          spk_q <= 1'b1;
          mic_q <= wdata[MIC_BIT];
        end
        ACC_READ: spk_q <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/legacy_io_port.sv
module legacy_io_port
  import legacy_io_pkg::*;
#(
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int COL_W   = COL_W_DEF,
  parameter int MIC_BIT = MIC_BIT_DEF,
  parameter int EAR_BIT = EAR_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [4:0]        key_cols_n,
  input  logic              tape_in,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [7:0]        key_rows_n,
  output logic              tape_out,
  output logic              spkr
);
  localparam int ROW_W = ADDR_W / 2;

  logic      rd_hit;
  logic      wr_hit;
  acc_kind_e kind;

  io_port_decode #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_dec (
    .addr   (bus_addr),
    .rd     (io_rd),
    .wr     (io_wr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit),
    .kind   (kind),
    .rows_n (key_rows_n)
  );

  io_read_mux #(.DATA_W(DATA_W), .COL_W(COL_W), .EAR_BIT(EAR_BIT)) u_mux (
    .rd_hit (rd_hit),
    .cols_n (key_cols_n),
    .ear    (tape_in),
    .data   (rd_data),
    .valid  (rd_valid)
  );

  io_out_regs #(.DATA_W(DATA_W), .MIC_BIT(MIC_BIT)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .kind  (kind),
    .wdata (bus_wdata),
    .mic_q (tape_out),
    .spk_q (spkr)
  );
endmodule

// File: rtl/legacy_io_port_chk.sv
module legacy_io_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        io_rd,
  input logic        io_wr,
  input logic [4:0]  key_cols_n,
  input logic        tape_in,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic [7:0]  key_rows_n,
  input logic        tape_out,
  input logic        spkr
);
  // R1
  odd_addr_quiet_chk: assert property (@(posedge clk)
    bus_addr[0] |-> (!rd_valid && key_rows_n == 8'hFF));

  // R2
  mic_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_addr[0] && io_wr) |=> (tape_out == $past(bus_wdata[3])));

  // R3
  wr_sets_spk_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_addr[0] && io_wr) |=> spkr);

  // R4
  rd_clears_spk_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_addr[0] && io_rd && !io_wr) |=> !spkr);

  // R5
  rd_word_chk: assert property (@(posedge clk)
    rd_valid |-> (rd_data[7:6] == 2'b11 && rd_data[5] == tape_in && rd_data[4:0] == key_cols_n));

  // R6
  rows_chk: assert property (@(posedge clk)
    rd_valid |-> (key_rows_n == bus_addr[15:8]));

  // R7
  idle_data_chk: assert property (@(posedge clk)
    !rd_valid |-> (rd_data == 8'hFF));

  // R9
  reset_chk: assert property (@(posedge clk)
    rst |=> (!spkr && !tape_out));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[0] || (!io_rd && !io_wr)) |=> ($stable(spkr) && $stable(tape_out)));
endmodule

bind legacy_io_port legacy_io_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .key_cols_n (key_cols_n),
  .tape_in    (tape_in),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .key_rows_n (key_rows_n),
  .tape_out   (tape_out),
  .spkr       (spkr)
);

// File: tb/test_legacy_io_port.sv
module test_legacy_io_port;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] data;
    logic       valid;
    logic [7:0] rows;
    string      tag;
  } comb_item_t;

  typedef struct {
    logic  spk;
    logic  mic;
    string tag;
  } reg_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [15:0] bus_addr = 16'h0001;
  logic [7:0]  bus_wdata = 8'h00;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [4:0]  key_cols_n = 5'h1F;
  logic        tape_in = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  key_rows_n;
  logic        tape_out;
  logic        spkr;

  int total = 0;
  int bad = 0;
  logic m_spk = 1'b0;
  logic m_mic = 1'b0;
  comb_item_t q_comb[$];
  reg_item_t  q_reg[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_io_port i_legacy_io_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .key_cols_n(key_cols_n), .tape_in(tape_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .key_rows_n(key_rows_n),
    .tape_out(tape_out), .spkr(spkr)
  );

  // Driver: applies one cycle of stimulus and queues what the requirements predict
  task automatic do_cycle(input logic r, input logic [15:0] a, input logic [7:0] d,
                          input logic rd, input logic wr, input logic [4:0] c,
                          input logic t, input string tag);
    comb_item_t ci;
    reg_item_t  ri;
    logic sel;
    @(negedge clk);
    rst = r; bus_addr = a; bus_wdata = d; io_rd = rd; io_wr = wr;
    key_cols_n = c; tape_in = t;
    sel = ~a[0];
    ci.valid = sel & rd;
    ci.rows  = ci.valid ? a[15:8] : 8'hFF;
    ci.data  = ci.valid ? {2'b11, t, c} : 8'hFF;
    ci.tag   = tag;
    q_comb.push_back(ci);
    if (r) begin
      m_spk = 1'b0; m_mic = 1'b0;
    end else if (sel && wr) begin
      m_spk = 1'b1; m_mic = d[3];
    end else if (sel && rd) begin
      m_spk = 1'b0;
    end
    ri.spk = m_spk; ri.mic = m_mic; ri.tag = tag;
    q_reg.push_back(ri);
  endtask

  // Monitor for the combinational read path, sampled after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_comb.size() > 0) begin
        comb_item_t e;
        e = q_comb.pop_front();
        total++;
        if (rd_data !== e.data || rd_valid !== e.valid || key_rows_n !== e.rows) begin
          bad++;
          $display("FAIL %s read path: got data=%h valid=%b rows=%h expected data=%h valid=%b rows=%h",
                   e.tag, rd_data, rd_valid, key_rows_n, e.data, e.valid, e.rows);
        end
      end
    end
  end

  // Monitor for the registered outputs, sampled just after the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_reg.size() > 0) begin
        reg_item_t e;
        e = q_reg.pop_front();
        total++;
        if (spkr !== e.spk || tape_out !== e.mic) begin
          bad++;
          $display("FAIL %s outputs: got spkr=%b tape_out=%b expected spkr=%b tape_out=%b",
                   e.tag, spkr, tape_out, e.spk, e.mic);
        end
      end
    end
  end

  initial begin
    fork
      begin
        do_cycle(1, 16'h0001, 8'h00, 0, 0, 5'h1F, 0, "R9 reset");
        do_cycle(0, 16'h0001, 8'h00, 0, 0, 5'h1F, 0, "R7 idle after reset");
        do_cycle(0, 16'h00FE, 8'h08, 0, 1, 5'h1F, 0, "R2 R3 write bit3=1");
        do_cycle(0, 16'h00FE, 8'h00, 0, 0, 5'h1F, 0, "R10 hold");
        do_cycle(0, 16'hFBFE, 8'h00, 1, 0, 5'b10110, 1, "R4 R5 R6 read");
        do_cycle(0, 16'h7F00, 8'h00, 1, 0, 5'b01111, 0, "R5 R6 read other even");
        do_cycle(0, 16'h00FF, 8'hFF, 0, 1, 5'h1F, 0, "R1 odd write ignored");
        do_cycle(0, 16'hFE01, 8'h00, 1, 0, 5'b00000, 1, "R1 odd read ignored");
        do_cycle(0, 16'h1234, 8'hF7, 0, 1, 5'h1F, 1, "R2 R3 write bit3=0 other bits set");
        do_cycle(0, 16'hEFFE, 8'h00, 1, 0, 5'b11011, 0, "R4 read clears");
        do_cycle(0, 16'hDF00, 8'h08, 1, 1, 5'b10101, 1, "R8 both strobes from clear");
        do_cycle(0, 16'hBF02, 8'h00, 1, 1, 5'b01010, 0, "R8 both strobes from set");
        do_cycle(0, 16'hBF03, 8'h08, 1, 1, 5'b00000, 1, "R1 R8 odd both ignored");
        do_cycle(0, 16'h00FE, 8'h00, 1, 0, 5'h1F, 1, "R4 R5 read");
        do_cycle(0, 16'h00FE, 8'h08, 0, 1, 5'h1F, 0, "R3 write again");
        do_cycle(0, 16'h00FE, 8'h08, 0, 1, 5'h1F, 0, "R3 held write");
        do_cycle(1, 16'h00FE, 8'h08, 0, 0, 5'h1F, 0, "R9 reset mid run");
        do_cycle(0, 16'h0001, 8'h00, 0, 0, 5'h1F, 0, "R10 idle after reset");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule